// File: doc/BRIEF.md
# Bus Cycle Tracker with Address Capture

This block sits on the system side of a processor bus and follows each bus cycle as it happens. It samples the address strobe on every clock. When the strobe is taken as a valid cycle start, the block captures address bits 31..3 and the cycle-definition bits in that same clock, so the values stay available after the address lines are released or driven by another master. It then counts ready strobes until the cycle is complete: one strobe ends a single-transfer cycle and four end a burst. The block raises a one-clock completion pulse at that point.

The block also follows a back-off takeover. The processor may leave the strobe line floating in its asserted state while back-off is held, so any strobe seen with back-off high is discarded. If a cycle is in flight when back-off arrives, the cycle is marked as aborted and waiting for a restart, and the ready count is thrown away. The strobe that restarts the cycle may come in the clock right after back-off is released. That strobe is compared with the captured address. Two other strobes are reported as protocol errors: one that arrives while a cycle is still open, and one that arrives in the clock right after a cycle's final ready, where an idle clock is required.

Top module: `bcyc_tracker`

## Requirements
- R1: After reset, every output is 0: the captured address, the captured definition, active, done, abort-pending, protocol error and restart match.
- R2: A strobe sampled with back-off low, no cycle open and the idle clock satisfied is accepted. From the next clock, the captured address and definition show the values present at that edge, and active is 1.
- R3: In a single-transfer cycle (burst input 0 at the strobe), the first ready sampled while active makes done 1 for exactly one clock and returns active to 0 in that same clock.
- R4: In a burst cycle (burst input 1 at the strobe), the first three ready strobes leave active at 1 and done at 0. The fourth ends the cycle as in R3.
- R5: Ready sampled while no cycle is open has no effect: done stays 0 and active stays 0.
- R6: A strobe sampled while a cycle is open raises the protocol error for one clock. The captured address is unchanged and the open cycle goes on counting.
- R7: A strobe sampled in the clock that directly follows a cycle's final ready raises the protocol error and is not accepted. A strobe two clocks after the final ready is accepted.
- R8: Back-off sampled while a cycle is open clears active and sets abort-pending from the next clock. Ready strobes counted before the abort are discarded, so a restarted burst needs four new ready strobes.
- R9: A strobe sampled while back-off is high is ignored: no capture, no error, and no change to active.
- R10: A strobe accepted while abort-pending is 1 may come in the clock right after back-off falls, with no idle clock required. It clears abort-pending. It pulses restart match for one clock when its address equals the captured one, and leaves restart match at 0 when the addresses differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ads_i | input | 1 | Address strobe, active high |
| rdy_i | input | 1 | Ready strobe, one per transfer, active high |
| boff_i | input | 1 | Back-off request, active high |
| burst_i | input | 1 | 1 marks the cycle starting at this strobe as a four-transfer burst |
| addr_i | input | ADDR_W (29) | Address bits 31..3 |
| cdef_i | input | DEF_W (3) | Cycle-definition bits |
| lat_addr_o | output | ADDR_W (29) | Captured address |
| lat_def_o | output | DEF_W (3) | Captured cycle definition |
| cyc_active_o | output | 1 | A cycle is open |
| cyc_done_o | output | 1 | One-clock pulse when a cycle completes |
| abort_pend_o | output | 1 | A cycle was aborted by back-off and is waiting for a restart |
| proto_err_o | output | 1 | One-clock pulse for a strobe that breaks the spacing rules |
| restart_match_o | output | 1 | One-clock pulse when a restart strobe carries the captured address |

## Verification
The bench sends single-transfer and burst cycles with ready strobes placed back to back and with gaps between them. The gapped patterns show that only counted beats advance the cycle, and the burst patterns tell a one-beat end apart from a four-beat end. Strobes are sent inside an open cycle, in the clock right after a final ready, and two clocks after it. Those three cases separate the open-cycle error, the idle-clock error and a legal start. Back-off is applied in the middle of a burst, with a strobe held during it, followed by restarts that use the same address and then a different one. These patterns check that the beat count is discarded, that the floating strobe is ignored, and that the restart comparison gives the right result.

// File: rtl/bcyc_pkg.sv
package bcyc_pkg;
   function automatic int unsigned beat_cnt_w(input int unsigned beats);
      return (beats < 2) ? 1 : $clog2(beats + 1);
   endfunction
endpackage

// File: rtl/bcyc_addr_latch.sv
module bcyc_addr_latch #(
   parameter int unsigned ADDR_W = 29,
   parameter int unsigned DEF_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DEF_W-1:0]  def_i,
   input  logic              burst_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DEF_W-1:0]  def_o,
   output logic              burst_o,
   output logic              same_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_o  <= '0;
         def_o   <= '0;
         burst_o <= 1'b0;
      end else if (load_i) begin
         addr_o  <= addr_i;
         def_o   <= def_i;
         burst_o <= burst_i;
      end
   end

   assign same_o = (addr_i == addr_o);
endmodule

// File: rtl/bcyc_beat_cnt.sv
module bcyc_beat_cnt
   import bcyc_pkg::*;
#(
   parameter int unsigned BURST_BEATS = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic inc_i,
   input  logic burst_i,
   output logic last_o
);
   localparam int unsigned CW = beat_cnt_w(BURST_BEATS);

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] need;

   assign need   = burst_i ? CW'(BURST_BEATS - 1) : '0;
   assign last_o = (cnt_q == need);

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/bcyc_gap_guard.sv
module bcyc_gap_guard #(
   parameter int unsigned MIN_GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic block_o
);
   generate
      if (MIN_GAP > 1) begin : g_guard
         localparam int unsigned GW = $clog2(MIN_GAP);
         logic [GW-1:0] gap_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             gap_q <= '0;
            else if (start_i)       gap_q <= GW'(MIN_GAP - 1);
            else if (gap_q != '0)   gap_q <= gap_q - 1'b1;
         end
         assign block_o = (gap_q != '0);
      end else begin : g_none
         logic unused_sig;
         assign unused_sig = start_i ^ clk ^ rst_n;
         assign block_o    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/bcyc_tracker.sv
module bcyc_tracker #(
   parameter int unsigned ADDR_W      = 29,
   parameter int unsigned DEF_W       = 3,
   parameter int unsigned BURST_BEATS = 4,
   parameter int unsigned MIN_GAP     = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ads_i,
   input  logic              rdy_i,
   input  logic              boff_i,
   input  logic              burst_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DEF_W-1:0]  cdef_i,
   output logic [ADDR_W-1:0] lat_addr_o,
   output logic [DEF_W-1:0]  lat_def_o,
   output logic              cyc_active_o,
   output logic              cyc_done_o,
   output logic              abort_pend_o,
   output logic              proto_err_o,
   output logic              restart_match_o
);
   if (ADDR_W < 1)      $error("ADDR_W must be at least 1");
   if (DEF_W < 1)       $error("DEF_W must be at least 1");
   if (BURST_BEATS < 2) $error("BURST_BEATS must be at least 2");

   logic ads_v, accept, busy_err, beat, last, fin, abort;
   logic gap_block, lat_burst, same_addr;
   logic active_q, pend_q, done_q, err_q, match_q;

   assign ads_v    = ads_i & ~boff_i;
   assign accept   = ads_v & ~active_q & ~gap_block;
   assign busy_err = ads_v & (active_q | gap_block);
   assign beat     = rdy_i & ~boff_i & active_q;
   assign fin      = beat & last;
   assign abort    = boff_i & active_q;

   bcyc_addr_latch #(.ADDR_W(ADDR_W), .DEF_W(DEF_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .addr_i  (addr_i),
      .def_i   (cdef_i),
      .burst_i (burst_i),
      .addr_o  (lat_addr_o),
      .def_o   (lat_def_o),
      .burst_o (lat_burst),
      .same_o  (same_addr)
   );

   bcyc_beat_cnt #(.BURST_BEATS(BURST_BEATS)) u_beats (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (accept | abort | fin),
      .inc_i   (beat & ~last),
      .burst_i (lat_burst),
      .last_o  (last)
   );

   bcyc_gap_guard #(.MIN_GAP(MIN_GAP)) u_gap (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (fin),
      .block_o (gap_block)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         pend_q   <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         match_q  <= 1'b0;
      end else begin
         if (accept)            active_q <= 1'b1;
         else if (fin | abort)  active_q <= 1'b0;
         if (accept)            pend_q <= 1'b0;
         else if (abort)        pend_q <= 1'b1;
         done_q  <= fin;
         err_q   <= busy_err;
         match_q <= accept & pend_q & same_addr;
      end
   end

   assign cyc_active_o    = active_q;
   assign abort_pend_o    = pend_q;
   assign cyc_done_o      = done_q;
   assign proto_err_o     = err_q;
   assign restart_match_o = match_q;
endmodule

// File: rtl/bcyc_tracker_chk.sv
module bcyc_tracker_chk #(
   parameter int unsigned ADDR_W = 29
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boff_i,
   input logic              cyc_done_o,
   input logic              cyc_active_o,
   input logic              abort_pend_o,
   input logic              proto_err_o,
   input logic [ADDR_W-1:0] lat_addr_o
);
   AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) cyc_done_o |=> !cyc_done_o); // R3
   AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) cyc_done_o |-> !cyc_active_o); // R4
   AST_BOFF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n) boff_i |=> !cyc_active_o); // R8
   AST_PEND_IDLE: assert property (@(posedge clk) disable iff (!rst_n) abort_pend_o |-> !cyc_active_o); // R8
   AST_BOFF_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) boff_i |=> $stable(lat_addr_o)); // R9
   AST_ERR_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) proto_err_o |-> $stable(lat_addr_o)); // R6
endmodule

bind bcyc_tracker bcyc_tracker_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .boff_i       (boff_i),
   .cyc_done_o   (cyc_done_o),
   .cyc_active_o (cyc_active_o),
   .abort_pend_o (abort_pend_o),
   .proto_err_o  (proto_err_o),
   .lat_addr_o   (lat_addr_o)
);

// File: tb/bcyc_tracker_tb.sv
module bcyc_tracker_tb;
   localparam int PERIOD = 10;
   localparam int AW = 29;
   localparam int DW = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ads = 1'b0, rdy = 1'b0, boff = 1'b0, burst = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] cdef = '0;
   logic [AW-1:0] lat_addr;
   logic [DW-1:0] lat_def;
   logic act, done, pend, err, match;

   always #(PERIOD/2) clk = ~clk;

   bcyc_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .ads_i(ads), .rdy_i(rdy), .boff_i(boff),
      .burst_i(burst), .addr_i(addr), .cdef_i(cdef),
      .lat_addr_o(lat_addr), .lat_def_o(lat_def), .cyc_active_o(act),
      .cyc_done_o(done), .abort_pend_o(pend), .proto_err_o(err),
      .restart_match_o(match)
   );

   typedef struct {
      logic          act, done, pend, err, match;
      logic [AW-1:0] addr;
      logic [DW-1:0] def;
      string         tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0, n_errs = 0;
   bit   finished = 0;

   // reference state built from the requirements
   logic          m_act = 0, m_pend = 0, m_burst = 0, m_gap = 0;
   int            m_beats = 0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_def = '0;

   task automatic step(input logic a, input logic r, input logic b, input logic bu,
                       input logic [AW-1:0] ad, input logic [DW-1:0] df, input string tag);
      exp_t e;
      logic gap_now;
      @(negedge clk);
      ads = a; rdy = r; boff = b; burst = bu; addr = ad; cdef = df;
      e.done = 0; e.err = 0; e.match = 0;
      gap_now = m_gap;
      m_gap = 0;
      if (b) begin
         if (m_act) begin m_act = 0; m_pend = 1; m_beats = 0; end
      end else if (a && !m_act && !gap_now) begin
         if (m_pend) e.match = (ad == m_addr);
         m_pend = 0; m_addr = ad; m_def = df; m_burst = bu; m_act = 1; m_beats = 0;
      end else begin
         if (a) e.err = 1;
         if (r && m_act) begin
            m_beats++;
            if (m_beats == (m_burst ? 4 : 1)) begin
               e.done = 1; m_act = 0; m_beats = 0; m_gap = 1;
            end
         end
      end
      e.act = m_act; e.pend = m_pend; e.addr = m_addr; e.def = m_def; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, '0, '0, tag);
   endtask

   initial begin : monitor
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (q.size() > 0) begin
            e = q.pop_front();
            n_checks++;
            if (act !== e.act || done !== e.done || pend !== e.pend || err !== e.err ||
                match !== e.match || lat_addr !== e.addr || lat_def !== e.def) begin
               n_errs++;
               $display("FAIL %s: got act=%b done=%b pend=%b err=%b match=%b addr=%h def=%h expected act=%b done=%b pend=%b err=%b match=%b addr=%h def=%h",
                        e.tag, act, done, pend, err, match, lat_addr, lat_def,
                        e.act, e.done, e.pend, e.err, e.match, e.addr, e.def);
            end
         end
      end
   end

   initial begin : watchdog
      #(PERIOD * 20000);
      if (!finished) begin
         n_errs++; n_checks++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin : driver
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2, "R1 reset state");
      // single transfer
      step(1, 0, 0, 0, 29'h0ABCDE1, 3'd5, "R2 capture single");
      step(0, 1, 0, 0, '0, '0, "R3 single done");
      idle(2, "R3 done pulse width");
      step(0, 1, 0, 0, '0, '0, "R5 ready while idle");
      idle(1, "R5 idle");
      // burst with spaced ready strobes
      step(1, 0, 0, 1, 29'h1234560, 3'd2, "R2 capture burst");
      step(0, 1, 0, 0, '0, '0, "R4 beat1");
      step(0, 0, 0, 0, '0, '0, "R4 wait");
      step(0, 1, 0, 0, '0, '0, "R4 beat2");
      step(1, 1, 0, 1, 29'h0FFFFFF, 3'd7, "R6 strobe while open");
      step(0, 1, 0, 0, '0, '0, "R4 beat4");
      // strobe right after final ready
      step(1, 0, 0, 0, 29'h0000111, 3'd1, "R7 strobe in idle clock");
      step(1, 0, 0, 0, 29'h0000222, 3'd3, "R7 strobe two after");
      step(0, 1, 0, 0, '0, '0, "R3 single done again");
      idle(2, "R7 idle");
      // back-off in the middle of a burst
      step(1, 0, 0, 1, 29'h0C0FFEE, 3'd4, "R2 capture burst b");
      step(0, 1, 0, 0, '0, '0, "R8 beat1");
      step(0, 1, 0, 0, '0, '0, "R8 beat2");
      step(0, 0, 1, 0, '0, '0, "R8 back-off abort");
      step(1, 0, 1, 1, 29'h1DEAD00, 3'd6, "R9 strobe during back-off");
      step(0, 1, 1, 0, '0, '0, "R9 ready during back-off");
      step(1, 0, 0, 1, 29'h0C0FFEE, 3'd4, "R10 restart same addr");
      step(0, 1, 0, 0, '0, '0, "R8 restart beat1");
      step(0, 1, 0, 0, '0, '0, "R8 restart beat2");
      step(0, 1, 0, 0, '0, '0, "R8 restart beat3");
      step(0, 1, 0, 0, '0, '0, "R8 restart beat4");
      idle(2, "R8 idle");
      // abort and restart with a different address
      step(1, 0, 0, 0, 29'h0055AA0, 3'd0, "R2 capture single b");
      step(0, 0, 1, 0, '0, '0, "R8 abort single");
      step(1, 0, 0, 0, 29'h0077770, 3'd2, "R10 restart other addr");
      step(0, 1, 0, 0, '0, '0, "R10 restart done");
      idle(3, "R10 idle");
      wait (q.size() == 0);
      @(negedge clk);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end
endmodule